// File: doc/BRIEF.md
# Program memory fetch strobe controller

This block chooses, once per machine cycle, whether the instruction fetch of that cycle is served by on-chip or off-chip program memory. For off-chip fetches it drives an active-low read strobe towards the external program memory, timed against a machine-cycle state sequencer that it also provides to the rest of the core.

A machine cycle is twelve clocks: six states of two clocks each. The inputs of the cycle are the external-access select, the program counter, the fetch request and the external-data flag. They are captured on the clock edge that ends state 6 and starts the next state 1. The captured values then hold for that whole cycle. An off-chip fetch cycle produces two strobe pulses, one starting in state 1 and one starting in state 4. A cycle flagged as an external data access produces none. All pins are plain control and status signals; there is no streaming interface and no back-pressure.

Top module: `prog_fetch_strobe`

## Requirements
- R1: A machine cycle lasts 12 clocks. `mc_state` counts 1 to 6, holds each value for 2 clocks, then wraps to 1.
- R2: While `rst_n` is low, `psen_n` is 1, `rom_sel` is 0 and `mc_state` is 1. The first machine cycle after reset produces no strobe pulse.
- R3: The cycle inputs are captured only on the edge that enters state 1. A change during a cycle does not alter `psen_n` or `rom_sel` in that cycle.
- R4: With `ea_sel`=1, `fetch_req`=1 and `pc` <= 16'h3FFF, the next cycle has `rom_sel`=1 and `psen_n` stays 1 for all 12 clocks.
- R5: With `ea_sel`=1, `fetch_req`=1 and `pc` > 16'h3FFF, the next cycle is an off-chip fetch: `rom_sel`=0 and the strobe pulses twice.
- R6: With `ea_sel`=0 and `fetch_req`=1, the next cycle is an off-chip fetch for any `pc`, including 16'h0000.
- R7: In an off-chip fetch cycle, `psen_n` is 0 at clock offsets 0 to 2 (state 1 onwards) and 6 to 8 (state 4 onwards). It is 1 at every other offset, where offset 0 is the first clock of state 1.
- R8: When `xdata_cycle`=1 is captured, neither strobe pulse of that cycle occurs.
- R9: When `fetch_req`=0 is captured, `psen_n` stays 1 and `rom_sel` is 0 for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ea_sel | input | 1 | External-access select; 1 allows on-chip code below the limit |
| pc | input | 16 | Program counter of the fetch |
| fetch_req | input | 1 | A fetch takes place in the coming cycle |
| xdata_cycle | input | 1 | The coming cycle accesses external data memory |
| psen_n | output | 1 | Active-low off-chip program memory read strobe |
| rom_sel | output | 1 | The current cycle fetches from on-chip memory |
| mc_state | output | 3 | Machine-cycle state, 1 to 6 |

## Verification
On every cycle, the assertions check several things. The state stays in range and wraps correctly. The strobe stays high whenever the captured cycle is an on-chip or external-data cycle. Each pulse falls only in state 1 or state 4 and lasts exactly three clocks. `rom_sel` is steady away from the cycle boundary. The exact pulse positions, the source decision at the address limit and under a low select, and the reset and mid-cycle input behaviour need the bench's directed scenarios. Those scenarios compare every clock of a machine cycle with an expected pattern.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef struct packed {
    logic fetch;
    logic rom;
    logic xdata;
  } cyc_cfg_t;
endpackage

// File: rtl/mc_sequencer.sv
module mc_sequencer #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int CLKS = STATES * PHASES,
  localparam int IW = $clog2(CLKS),
  localparam int SW = $clog2(STATES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] clk_idx,
  output logic          last_clk,
  output logic [SW-1:0] state_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) clk_idx <= '0;
    else if (last_clk) clk_idx <= '0;
    else clk_idx <= clk_idx + IW'(1);
  end

  assign last_clk = (clk_idx == IW'(CLKS - 1));
  assign state_idx = SW'(clk_idx / IW'(PHASES)) + SW'(1);

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idx >= SW'(1)) && (state_idx <= SW'(STATES))); // R1
  AST_STATE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idx == SW'(STATES) && $past(state_idx) == SW'(STATES) && $past(rst_n))
      |=> state_idx == SW'(1)); // R1
endmodule

// File: rtl/fetch_source_sel.sv
module fetch_source_sel
  import pfs_pkg::*;
#(
  parameter int PC_W = 16,
  parameter logic [PC_W-1:0] ROM_LIMIT = 16'h3FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            ea_sel,
  input  logic [PC_W-1:0] pc,
  input  logic            fetch_req,
  input  logic            xdata_cycle,
  output cyc_cfg_t        cfg
);
  logic on_chip;
  assign on_chip = ea_sel && (pc <= ROM_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= '0;
    else if (load) begin
      cfg.fetch <= fetch_req;
      cfg.rom   <= on_chip;
      cfg.xdata <= xdata_cycle;
    end
  end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import pfs_pkg::*;
#(
  parameter int PHASES = 2,
  parameter int CLKS = 12,
  parameter int STROBE_LEN = 3,
  parameter int SECOND_STATE = 4,
  localparam int IW = $clog2(CLKS),
  localparam int NPULSE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] clk_idx,
  input  cyc_cfg_t      cfg,
  output logic          psen_n
);
  logic [NPULSE-1:0] in_win;
  logic ext_active;

  for (genvar i = 0; i < NPULSE; i++) begin : g_win
    localparam int START = (i == 0) ? 0 : (SECOND_STATE - 1) * PHASES;
    assign in_win[i] = (int'(clk_idx) >= START) && (int'(clk_idx) < START + STROBE_LEN);
  end

  assign ext_active = cfg.fetch && !cfg.rom && !cfg.xdata;
  assign psen_n = !(ext_active && (|in_win));

  AST_NO_STROBE_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.rom |-> psen_n); // R4
  AST_NO_STROBE_XDATA: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.xdata |-> psen_n); // R8
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(psen_n) && $past(rst_n)) |=> !psen_n); // R7
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n && $past(!psen_n) && $past(!psen_n, 2)) |=> psen_n); // R7
endmodule

// File: rtl/prog_fetch_strobe.sv
module prog_fetch_strobe
  import pfs_pkg::*;
#(
  parameter int PC_W = 16,
  parameter logic [PC_W-1:0] ROM_LIMIT = 16'h3FFF,
  parameter int STATES = 6,
  parameter int PHASES = 2,
  parameter int STROBE_LEN = 3,
  parameter int SECOND_STATE = 4,
  localparam int CLKS = STATES * PHASES,
  localparam int IW = $clog2(CLKS),
  localparam int SW = $clog2(STATES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ea_sel,
  input  logic [PC_W-1:0] pc,
  input  logic            fetch_req,
  input  logic            xdata_cycle,
  output logic            psen_n,
  output logic            rom_sel,
  output logic [SW-1:0]   mc_state
);
  logic [IW-1:0] clk_idx;
  logic          last_clk;
  cyc_cfg_t      cfg;

  mc_sequencer #(.STATES(STATES), .PHASES(PHASES)) u_seq (
    .clk(clk), .rst_n(rst_n), .clk_idx(clk_idx),
    .last_clk(last_clk), .state_idx(mc_state)
  );

  fetch_source_sel #(.PC_W(PC_W), .ROM_LIMIT(ROM_LIMIT)) u_src (
    .clk(clk), .rst_n(rst_n), .load(last_clk), .ea_sel(ea_sel), .pc(pc),
    .fetch_req(fetch_req), .xdata_cycle(xdata_cycle), .cfg(cfg)
  );

  strobe_gen #(.PHASES(PHASES), .CLKS(CLKS), .STROBE_LEN(STROBE_LEN),
               .SECOND_STATE(SECOND_STATE)) u_stb (
    .clk(clk), .rst_n(rst_n), .clk_idx(clk_idx), .cfg(cfg), .psen_n(psen_n)
  );

  assign rom_sel = cfg.fetch && cfg.rom;

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_clk && $past(rst_n)) |=> $stable(rom_sel)); // R3
  AST_STROBE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> (mc_state == SW'(1) || mc_state == SW'(SECOND_STATE))); // R7
  AST_ROM_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> psen_n); // R4
endmodule

// File: tb/tb_prog_fetch_strobe.sv
module tb_prog_fetch_strobe;
  logic clk = 0;
  logic rst_n = 0;
  logic ea_sel = 0;
  logic [15:0] pc = '0;
  logic fetch_req = 0;
  logic xdata_cycle = 0;
  logic psen_n, rom_sel;
  logic [2:0] mc_state;
  int total = 0;
  int bad = 0;
  bit done = 0;

  prog_fetch_strobe dut (
    .clk(clk), .rst_n(rst_n), .ea_sel(ea_sel), .pc(pc), .fetch_req(fetch_req),
    .xdata_cycle(xdata_cycle), .psen_n(psen_n), .rom_sel(rom_sel), .mc_state(mc_state)
  );

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic to_cycle_start();
    while (mc_state == 3'd1) @(negedge clk);
    while (mc_state != 3'd1) @(negedge clk);
  endtask

  // Set inputs during a cycle, then check every clock of the following cycle.
  task automatic run_cycle(string req, bit ea, logic [15:0] p, bit f, bit xd, bit flip);
    bit exp_rom, ext;
    to_cycle_start();
    ea_sel = ea; pc = p; fetch_req = f; xdata_cycle = xd;
    exp_rom = f && ea && (p <= 16'h3FFF);
    ext = f && !xd && !(ea && (p <= 16'h3FFF));
    to_cycle_start();
    for (int k = 0; k < 12; k++) begin
      if (flip && k == 4) begin
        ea_sel = !ea; pc = ea ? 16'hFFFF : 16'h0000; xdata_cycle = !xd;
      end
      check({req, "/R1 state"}, mc_state, k / 2 + 1);
      check({req, "/R7 strobe"}, psen_n, (ext && ((k <= 2) || (k >= 6 && k <= 8))) ? 0 : 1);
      check({req, " rom_sel"}, rom_sel, exp_rom);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; ea_sel = 0; fetch_req = 1; xdata_cycle = 0; pc = 16'h8000;
    repeat (5) @(negedge clk);
    check("R2 psen_n", psen_n, 1);
    check("R2 rom_sel", rom_sel, 0);
    check("R2 state", mc_state, 1);
    rst_n = 1;
    for (int k = 0; k < 12; k++) begin
      check("R2 first cycle psen_n", psen_n, 1);
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog expired actual=0 expected=1");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    run_cycle("R4 rom limit", 1, 16'h3FFF, 1, 0, 0);
    run_cycle("R4 rom low", 1, 16'h0123, 1, 0, 0);
    run_cycle("R5 above limit", 1, 16'h4000, 1, 0, 0);
    run_cycle("R5 top", 1, 16'hFFFF, 1, 0, 0);
    run_cycle("R6 ea low pc0", 0, 16'h0000, 1, 0, 0);
    run_cycle("R6 ea low mid", 0, 16'h2000, 1, 0, 0);
    run_cycle("R8 xdata", 0, 16'h0000, 1, 1, 0);
    run_cycle("R8 xdata high pc", 1, 16'h9000, 1, 1, 0);
    run_cycle("R9 no fetch", 0, 16'h0000, 0, 0, 0);
    run_cycle("R9 no fetch rom", 1, 16'h0010, 0, 0, 0);
    run_cycle("R3 flip ext", 0, 16'h1000, 1, 0, 1);
    run_cycle("R3 flip rom", 1, 16'h0100, 1, 1, 1);
    run_cycle("R7 back to back", 0, 16'h5555, 1, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule